// File: doc/BRIEF.md
# Way-Predicted Two-Way Read Cache

This block is a two-way set-associative read cache that stores a one-bit way guess for every set. When a lookup starts, the stored guess steers the data multiplexer straight away, and only the guessed way's tag is compared. If the guess is right, the word comes back one cycle after the request is accepted. If the guess is wrong, the other way is compared in the next cycle. A match there is a slow hit: it costs two cycles, and the guess for that set moves to the way that matched. If neither way matches, the block asks the next level for the word, waits for it, writes it into the least recently used way, and returns it.

A requester sends one address at a time over a valid/ready port. Every response carries a latency code, so the requester, or a bench, can tell a fast hit, a slow hit and a miss apart and can check each one's cycle count. The set index is taken from the low address bits and the tag from the rest. Each line holds one data word.

The controller has four states. **IDLE** accepts a request. **FIRST** compares the guessed way. **SECOND** compares the other way. **REFILL** holds the fill request until the word arrives. The transitions are:
- IDLE to FIRST when a request is accepted.
- FIRST to IDLE on a fast hit.
- FIRST to SECOND on a wrong guess.
- SECOND to IDLE on a slow hit.
- SECOND to REFILL on a miss.
- REFILL to IDLE when the fill word arrives.

Top module: `wpc_cache`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `fill_req` is 0. Every line is invalid, so the first access to any address misses. Every set's guess and LRU pointer start at way 0.
- R2: If the guessed way holds the tag, `rsp_valid` rises in the first cycle after acceptance, with `rsp_lat` = 2'b01 and that way's data.
- R3: If only the other way holds the tag, `rsp_valid` rises in the second cycle after acceptance, with `rsp_lat` = 2'b10. The set's guess then names the way that matched, so a repeat of the same address is a fast hit.
- R4: If neither way holds the tag, `fill_req` is raised from the third cycle after acceptance, with `fill_addr` equal to the request address, and stays high until `fill_valid`. The response comes in the same cycle as `fill_valid`, with `rsp_lat` = 2'b11 and `fill_data`.
- R5: A refill writes the set's least recently used way. Any hit or refill makes the way it used the most recent one.
- R6: After a refill, the set's guess names the refilled way, so a repeat of that address is a fast hit.
- R7: `fill_valid` is ignored when no fill is outstanding. It produces no response and changes no stored line.
- R8: `req_ready` is 1 only when no access is in progress. Each accepted request gets exactly one response. Sets are indexed by `req_addr[IDX_W-1:0]` and are independent of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_addr | input | ADDR_W | Word address of the lookup |
| req_ready | output | 1 | Controller idle; a request is accepted on this edge |
| rsp_valid | output | 1 | Response word valid this cycle |
| rsp_data | output | DATA_W | Returned word |
| rsp_lat | output | 2 | 01 fast hit, 10 slow hit, 11 miss, 00 when idle |
| fill_req | output | 1 | Fill request to the next level |
| fill_addr | output | ADDR_W | Address being filled |
| fill_valid | input | 1 | Fill word present |
| fill_data | input | DATA_W | Fill word |

## Verification
A wrong guess bit never returns bad data. It shows up only as a latency code of 10 where 01 was due, on the next access to that set. A bench therefore has to predict the latency of every access, not just the data. A wrong LRU pointer evicts the wrong line. That surfaces later, as an unexpected miss, or as a hit returning a word that belongs to a different address, whenever the evicted address is touched again. The reference model tracks the tags, guess bits and LRU pointers of every set, and compares the latency code, the data and the cycle count of each response.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2,
        ST_REFILL = 2'd3
    } wpc_state_e;

    typedef enum logic [1:0] {
        LAT_NONE = 2'b00,
        LAT_FAST = 2'b01,
        LAT_SLOW = 2'b10,
        LAT_MISS = 2'b11
    } wpc_lat_e;
endpackage

// File: rtl/wpc_way_store.sv
module wpc_way_store #(
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int SETS = 1 << IDX_W;

    logic [SETS-1:0]   valid_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [DATA_W-1:0] data_q [SETS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            data_q[wr_idx] <= wr_data;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_data  = data_q[rd_idx];

    // R5: a refilled line is valid on the next cycle
    a_r5_fill_makes_valid: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> valid_q[$past(wr_idx)]);
endmodule

// File: rtl/wpc_set_state.sv
module wpc_set_state #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_pred,
    output logic             rd_lru,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_way
);
    localparam int SETS = 1 << IDX_W;

    logic [SETS-1:0] pred_q;
    logic [SETS-1:0] lru_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pred_q <= '0;
            lru_q  <= '0;
        end else if (upd_en) begin
            pred_q[upd_idx] <= upd_way;
            lru_q[upd_idx]  <= ~upd_way;
        end
    end

    assign rd_pred = pred_q[rd_idx];
    assign rd_lru  = lru_q[rd_idx];

    // R3, R6: the guess follows the way last used
    a_r6_guess_follows_use: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> pred_q[$past(upd_idx)] == $past(upd_way));
    // R5: the way just used is no longer the eviction candidate
    a_r5_lru_points_away: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> lru_q[$past(upd_idx)] != $past(upd_way));
endmodule

// File: rtl/wpc_ctrl.sv
module wpc_ctrl
    import wpc_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic [ADDR_W-1:0] cur_addr,
    input  logic              hit_pred,
    input  logic              hit_alt,
    input  logic              pred_way,
    input  logic              lru_way,
    input  logic              fill_valid,
    output logic              fill_req,
    output logic              rsp_valid,
    output logic [1:0]        rsp_lat,
    output logic              sel_way,
    output logic              use_fill,
    output logic              upd_en,
    output logic              upd_way,
    output logic              wr_en
);
    wpc_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cur_addr <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_valid) begin
                cur_addr <= req_addr;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid)  state_d = ST_FIRST;
            ST_FIRST:  state_d = hit_pred ? ST_IDLE : ST_SECOND;
            ST_SECOND: state_d = hit_alt  ? ST_IDLE : ST_REFILL;
            ST_REFILL: if (fill_valid) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready = 1'b0;
        fill_req  = 1'b0;
        rsp_valid = 1'b0;
        rsp_lat   = LAT_NONE;
        sel_way   = pred_way;
        use_fill  = 1'b0;
        upd_en    = 1'b0;
        upd_way   = pred_way;
        wr_en     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
            end
            ST_FIRST: begin
                if (hit_pred) begin
                    rsp_valid = 1'b1;
                    rsp_lat   = LAT_FAST;
                    upd_en    = 1'b1;
                end
            end
            ST_SECOND: begin
                sel_way = ~pred_way;
                upd_way = ~pred_way;
                if (hit_alt) begin
                    rsp_valid = 1'b1;
                    rsp_lat   = LAT_SLOW;
                    upd_en    = 1'b1;
                end
            end
            ST_REFILL: begin
                fill_req = 1'b1;
                upd_way  = lru_way;
                if (fill_valid) begin
                    rsp_valid = 1'b1;
                    rsp_lat   = LAT_MISS;
                    use_fill  = 1'b1;
                    upd_en    = 1'b1;
                    wr_en     = 1'b1;
                end
            end
            default: ;
        endcase
    end

    // R2: a fast hit answers in the cycle right after acceptance
    a_r2_fast_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_lat == LAT_FAST) |-> $past(req_valid && req_ready));
    // R3: a slow hit answers two cycles after acceptance
    a_r3_slow_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_lat == LAT_SLOW) |-> $past(req_valid && req_ready, 2));
    // R4: fill request held with a steady address until the word arrives
    a_r4_fill_held: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && !fill_valid) |=> (fill_req && $stable(cur_addr)));
    // R8: an accepted request makes the controller busy
    a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
endmodule

// File: rtl/wpc_cache.sv
module wpc_cache
    import wpc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [1:0]        rsp_lat,
    output logic              fill_req,
    output logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_valid,
    input  logic [DATA_W-1:0] fill_data
);
    localparam int TAG_W = ADDR_W - IDX_W;
    localparam int WAYS  = 2;

    logic [ADDR_W-1:0] cur_addr;
    logic [IDX_W-1:0]  cur_idx;
    logic [TAG_W-1:0]  cur_tag;
    logic              pred_way, lru_way;
    logic              hit_pred, hit_alt;
    logic              sel_way, use_fill, upd_en, upd_way, wr_en;

    logic              way_valid [WAYS];
    logic [TAG_W-1:0]  way_tag   [WAYS];
    logic [DATA_W-1:0] way_data  [WAYS];

    assign cur_idx = cur_addr[IDX_W-1:0];
    assign cur_tag = cur_addr[ADDR_W-1:IDX_W];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        wpc_way_store #(
            .IDX_W (IDX_W),
            .TAG_W (TAG_W),
            .DATA_W(DATA_W)
        ) u_store (
            .clk     (clk),
            .rst_n   (rst_n),
            .rd_idx  (cur_idx),
            .rd_valid(way_valid[w]),
            .rd_tag  (way_tag[w]),
            .rd_data (way_data[w]),
            .wr_en   (wr_en && (upd_way == w[0])),
            .wr_idx  (cur_idx),
            .wr_tag  (cur_tag),
            .wr_data (fill_data)
        );
    end

    wpc_set_state #(.IDX_W(IDX_W)) u_sets (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (cur_idx),
        .rd_pred(pred_way),
        .rd_lru (lru_way),
        .upd_en (upd_en),
        .upd_idx(cur_idx),
        .upd_way(upd_way)
    );

    assign hit_pred = way_valid[pred_way]  && (way_tag[pred_way]  == cur_tag);
    assign hit_alt  = way_valid[~pred_way] && (way_tag[~pred_way] == cur_tag);

    wpc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_ready (req_ready),
        .cur_addr  (cur_addr),
        .hit_pred  (hit_pred),
        .hit_alt   (hit_alt),
        .pred_way  (pred_way),
        .lru_way   (lru_way),
        .fill_valid(fill_valid),
        .fill_req  (fill_req),
        .rsp_valid (rsp_valid),
        .rsp_lat   (rsp_lat),
        .sel_way   (sel_way),
        .use_fill  (use_fill),
        .upd_en    (upd_en),
        .upd_way   (upd_way),
        .wr_en     (wr_en)
    );

    assign rsp_data  = use_fill ? fill_data : way_data[sel_way];
    assign fill_addr = cur_addr;

    // R4: a miss response carries the fill word in its arrival cycle
    a_r4_miss_data_from_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_lat == LAT_MISS) |-> (fill_valid && rsp_data == fill_data));
    // R7: fill words arriving while idle produce no response
    a_r7_stray_fill_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !fill_req) |-> !rsp_valid);
endmodule

// File: tb/tb_wpc_cache.sv
module tb_wpc_cache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_ready;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic [1:0]  rsp_lat;
    logic        fill_req;
    logic [15:0] fill_addr;
    logic        fill_valid = 1'b0;
    logic [31:0] fill_data = '0;

    int errors = 0;
    int checks = 0;
    bit stray = 1'b0;
    logic [15:0] pend_addr = '0;

    bit        mval  [16][2];
    bit [11:0] mtag  [16][2];
    bit        mpred [16];
    bit        mlru  [16];

    always #5 clk = ~clk;

    wpc_cache dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_lat(rsp_lat), .fill_req(fill_req), .fill_addr(fill_addr),
        .fill_valid(fill_valid), .fill_data(fill_data)
    );

    function automatic logic [31:0] memf(input logic [15:0] a);
        return {a, a ^ 16'hA5A5};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model(input logic [15:0] a, output int lat);
        int idx;
        int p;
        int w;
        idx = int'(a[3:0]);
        p   = int'(mpred[idx]);
        if (mval[idx][p] && mtag[idx][p] == a[15:4]) begin
            lat = 1; w = p;
        end else if (mval[idx][1-p] && mtag[idx][1-p] == a[15:4]) begin
            lat = 2; w = 1 - p;
        end else begin
            lat = 3; w = int'(mlru[idx]);
            mval[idx][w] = 1'b1;
            mtag[idx][w] = a[15:4];
        end
        mpred[idx] = w[0];
        mlru[idx]  = ~w[0];
    endtask

    task automatic access(input logic [15:0] a, input string req);
        int lat;
        int n;
        bit busy_ok;
        do begin
            @(negedge clk); #2;
        end while (!req_ready);
        model(a, lat);
        pend_addr = a;
        req_valid = 1'b1;
        req_addr  = a;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        #2;
        n = 1;
        busy_ok = 1'b1;
        while (!rsp_valid && n < 64) begin
            if (req_ready) busy_ok = 1'b0;
            @(negedge clk); #2;
            n++;
        end
        check(busy_ok, "R8", "ready low while busy", 32'(req_ready), 32'd0);
        check(32'(rsp_lat) == 32'(lat), req, "latency code", 32'(rsp_lat), 32'(lat));
        check(rsp_data == memf(a), req, "data", rsp_data, memf(a));
        if (lat == 3)
            check(n >= 3 && fill_valid, req, "miss cycle", 32'(n), 32'd3);
        else
            check(n == lat, req, "hit cycle", 32'(n), 32'(lat));
    endtask

    // next-level responder
    initial begin
        int d;
        forever begin
            @(negedge clk);
            if (stray) begin
                fill_valid = 1'b1;
                fill_data  = 32'hBAD0_BAD0;
                #2;
                check(!rsp_valid, "R7", "stray fill response", 32'(rsp_valid), 32'd0);
                @(negedge clk);
                fill_valid = 1'b0;
                stray = 1'b0;
            end else if (fill_req) begin
                check(fill_addr == pend_addr, "R4", "fill address", 32'(fill_addr), 32'(pend_addr));
                d = int'(pend_addr[1:0]);
                repeat (d) @(negedge clk);
                check(fill_req, "R4", "fill request held", 32'(fill_req), 32'd1);
                fill_valid = 1'b1;
                fill_data  = memf(fill_addr);
                @(negedge clk);
                fill_valid = 1'b0;
                fill_data  = '0;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int s = 0; s < 16; s++) begin
            mpred[s] = 1'b0;
            mlru[s]  = 1'b0;
            for (int w = 0; w < 2; w++) begin
                mval[s][w] = 1'b0;
                mtag[s][w] = '0;
            end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        check(req_ready && !rsp_valid && !fill_req, "R1", "reset outputs",
              {29'd0, req_ready, rsp_valid, fill_req}, 32'd4);

        access(16'h0010, "R1");   // cold miss into way 0
        access(16'h0010, "R6");   // guess names refilled way: fast
        access(16'h0020, "R4");   // conflict miss into way 1
        access(16'h0010, "R3");   // guess wrong, other way hits: slow
        access(16'h0010, "R3");   // guess moved: fast
        access(16'h0020, "R3");   // slow again
        access(16'h0030, "R5");   // evicts LRU way (holds 0x0010)
        access(16'h0010, "R5");   // evicted, misses; evicts 0x0020
        access(16'h0030, "R5");   // still present
        access(16'h0025, "R8");   // other set unaffected by set 0 traffic

        stray = 1'b1;
        while (stray) @(negedge clk);
        access(16'h0030, "R7");
        access(16'h0010, "R7");

        for (int i = 0; i < 300; i++) begin
            logic [15:0] a;
            a = {12'(($urandom % 3) + 1), 4'($urandom % 16)};
            access(a, "R8");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule